// File: doc/BRIEF.md
# Peripheral Read Strobe Sequencer

This block fetches one byte from an external 8-bit asynchronous peripheral and pushes it into a local FIFO. A one-cycle start pulse launches the operation, but only while the sequencer is idle. The block first checks the peripheral's data-available status, which passes through a synchronizer. If data is available, the block drives an active-low read strobe across three fixed phases. The bus is pushed into the FIFO during the middle phase, and the block then returns to idle.

If the peripheral reports that it is empty, the operation does not end. The sequencer parks in a stall state, keeps the strobe released and raises an empty flag toward the controller. It stays there until the controller asserts abort. Abort also cancels any other operation in progress within one clock.

Top module: `pstrobe_reader`

## Requirements
- R1: While reset is asserted and on the first cycle after it, rd_n_o is 1 and busy_o, empty_flag_o and fifo_push_o are 0.
- R2: A start_i seen in idle makes busy_o 1 on the next cycle (the check cycle). The status evaluated there is pstat_i as sampled SYNC_STAGES clock edges earlier (2 by default).
- R3: When the evaluated status is 1 (data available), rd_n_o is 0 for STROBE_CYC (3) cycles, then 1 latch cycle, then TAIL_CYC (1) cycle. These are 5 consecutive low cycles, starting the cycle after the check cycle.
- R4: fifo_push_o is 1 for exactly one cycle, the latch cycle, which is the first low cycle after the STROBE_CYC strobe cycles. In that cycle fifo_data_o equals bus_i.
- R5: When fifo_full_i is 1 during the latch cycle, fifo_push_o stays 0 and the strobe timing is unchanged.
- R6: When the evaluated status is 0, the block enters a stall state with rd_n_o at 1, empty_flag_o at 1 and busy_o at 1. It remains there for as long as abort_i is 0.
- R7: abort_i at a clock edge puts the block in idle for the following cycle. It then shows rd_n_o at 1, busy_o at 0, empty_flag_o at 0 and no push. Abort takes priority over a simultaneous start.
- R8: A start_i received while busy_o is 1 has no effect: it neither restarts nor lengthens the running operation, nor does it leave the stall state.
- R9: busy_o is 1 in every non-idle cycle and 0 in idle.
- R10: A successful fetch keeps busy_o high for exactly 2 + STROBE_CYC + TAIL_CYC cycles (6 by default) and then returns to idle with no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to fetch a byte |
| abort_i | input | 1 | Forces return to idle |
| pstat_i | input | 1 | Peripheral status, 1 = data available, 0 = empty (asynchronous) |
| bus_i | input | DATA_W | Peripheral data bus |
| fifo_full_i | input | 1 | FIFO cannot accept a push |
| fifo_push_o | output | 1 | FIFO write enable |
| fifo_data_o | output | DATA_W | FIFO write data |
| rd_n_o | output | 1 | Read strobe, active low |
| empty_flag_o | output | 1 | Peripheral empty, waiting for abort |
| busy_o | output | 1 | Sequencer not idle |

## Verification
A wrong state or phase count appears at rd_n_o and busy_o on the very next cycle. Each run of low strobe cycles and each busy window therefore has a single correct length, and the per-cycle reference model catches any deviation at once. A push in the wrong phase shows up as a mismatch between fifo_push_o and the model in that cycle. A broken synchronizer shows up as a wrong choice between strobe and stall when the status changes one cycle before start. A stall that ends early, or an abort that is not obeyed, shows up one cycle later as a wrong empty_flag_o or busy_o.

// File: rtl/pstrobe_pkg.sv
package pstrobe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_CHECK  = 3'd1,
      ST_STROBE = 3'd2,
      ST_LATCH  = 3'd3,
      ST_TAIL   = 3'd4,
      ST_STALL  = 3'd5
   } rdseq_state_e;

   function automatic logic strobe_on(input rdseq_state_e s);
      return (s == ST_STROBE) || (s == ST_LATCH) || (s == ST_TAIL);
   endfunction

endpackage

// File: rtl/pstrobe_sync.sv
module pstrobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("pstrobe_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign sync_o = async_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
               if (!rst_n) sh_q <= '0;
               else        sh_q <= async_i;
            end
         end else begin : g_many
            always_ff @(posedge clk) begin
               if (!rst_n) sh_q <= '0;
               else        sh_q <= {sh_q[STAGES-2:0], async_i};
            end
         end
         assign sync_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pstrobe_timer.sv
module pstrobe_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] lim_i,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;

   assign done_o = (cnt_q == lim_i);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (!done_o) cnt_q <= cnt_q + 1'b1;
   end

   // phase counter never runs past the limit of the phase it times (R3)
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim_i);

endmodule

// File: rtl/pstrobe_fsm.sv
module pstrobe_fsm
   import pstrobe_pkg::*;
#(
   parameter int STROBE_CYC = 3,
   parameter int TAIL_CYC   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   input  logic stat_i,
   input  logic fifo_full_i,
   output logic fifo_push_o,
   output logic rd_n_o,
   output logic empty_flag_o,
   output logic busy_o
);

   localparam int MAX_LEN = (STROBE_CYC > TAIL_CYC) ? STROBE_CYC : TAIL_CYC;
   localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
   localparam logic [CNT_W-1:0] STROBE_LIM = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] TAIL_LIM   = CNT_W'(TAIL_CYC - 1);

   generate
      if (STROBE_CYC < 1 || TAIL_CYC < 1) begin : g_bad
         $error("pstrobe_fsm: phase lengths must be at least one cycle");
      end
   endgenerate

   rdseq_state_e     st_q, st_d;
   logic [CNT_W-1:0] lim;
   logic             ph_done;
   logic             ph_clr;

   always_comb begin
      unique case (st_q)
         ST_STROBE: lim = STROBE_LIM;
         ST_TAIL:   lim = TAIL_LIM;
         default:   lim = '0;
      endcase
   end

   always_comb begin
      st_d = st_q;
      if (abort_i) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:   if (start_i) st_d = ST_CHECK;
            ST_CHECK:  st_d = stat_i ? ST_STROBE : ST_STALL;
            ST_STROBE: if (ph_done) st_d = ST_LATCH;
            ST_LATCH:  st_d = ST_TAIL;
            ST_TAIL:   if (ph_done) st_d = ST_IDLE;
            ST_STALL:  st_d = ST_STALL;
            default:   st_d = ST_IDLE;
         endcase
      end
   end

   assign ph_clr = (st_d != st_q);

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   pstrobe_timer #(.CNT_W(CNT_W)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (ph_clr),
      .lim_i  (lim),
      .done_o (ph_done)
   );

   assign rd_n_o       = !strobe_on(st_q);
   assign fifo_push_o  = (st_q == ST_LATCH) && !fifo_full_i;
   assign empty_flag_o = (st_q == ST_STALL);
   assign busy_o       = (st_q != ST_IDLE);

   // busy only rises after a start request (R2)
   p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));
   // strobe assertion begins right after the check cycle (R3)
   p_strobe_after_check_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n_o) |-> $past(st_q == ST_CHECK));
   // a push happens only while the strobe is held low (R4)
   p_push_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push_o |-> !rd_n_o && $past(!rd_n_o));
   // never push into a full FIFO (R5)
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push_o |-> !fifo_full_i);
   // stall holds with strobe released until abort (R6)
   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_flag_o && !abort_i) |=> (empty_flag_o && rd_n_o));
   // abort returns to idle within one clock (R7)
   p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!busy_o && rd_n_o && !empty_flag_o));
   // start during a strobe run does not restart it (R8)
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_STROBE && start_i && !abort_i) |=> (st_q == ST_STROBE || st_q == ST_LATCH));

endmodule

// File: rtl/pstrobe_reader.sv
module pstrobe_reader #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int STROBE_CYC  = 3,
   parameter int TAIL_CYC    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic              pstat_i,
   input  logic [DATA_W-1:0] bus_i,
   input  logic              fifo_full_i,
   output logic              fifo_push_o,
   output logic [DATA_W-1:0] fifo_data_o,
   output logic              rd_n_o,
   output logic              empty_flag_o,
   output logic              busy_o
);

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("pstrobe_reader: DATA_W must be positive");
      end
   endgenerate

   logic stat_s;

   pstrobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pstat_i),
      .sync_o  (stat_s)
   );

   pstrobe_fsm #(
      .STROBE_CYC (STROBE_CYC),
      .TAIL_CYC   (TAIL_CYC)
   ) i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .abort_i      (abort_i),
      .stat_i       (stat_s),
      .fifo_full_i  (fifo_full_i),
      .fifo_push_o  (fifo_push_o),
      .rd_n_o       (rd_n_o),
      .empty_flag_o (empty_flag_o),
      .busy_o       (busy_o)
   );

   assign fifo_data_o = bus_i;

endmodule

// File: tb/test_pstrobe_reader.sv
module test_pstrobe_reader;

   localparam int CLK_PERIOD = 10;
   localparam int STROBE_N   = 3;
   localparam int TAIL_N     = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, abort_i = 1'b0, pstat_i = 1'b0, fifo_full_i = 1'b0;
   logic [7:0] bus_i = 8'h00;
   logic       fifo_push_o, rd_n_o, empty_flag_o, busy_o;
   logic [7:0] fifo_data_o;

   int tests = 0, fails = 0;
   int push_cnt = 0, busy_cnt = 0;
   logic [7:0] last_push = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   pstrobe_reader i_pstrobe_reader (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .pstat_i(pstat_i), .bus_i(bus_i), .fifo_full_i(fifo_full_i),
      .fifo_push_o(fifo_push_o), .fifo_data_o(fifo_data_o), .rd_n_o(rd_n_o),
      .empty_flag_o(empty_flag_o), .busy_o(busy_o)
   );

   // behavioural reference: mode name plus remaining cycles in the phase
   string m_mode = "idle";
   int    m_left = 0;
   bit    m_hist[$];

   always @(posedge clk) begin
      bit seen;
      seen = (m_hist.size() >= 2) ? m_hist[m_hist.size()-2] : 1'b0;
      if (!rst_n) begin
         m_mode = "idle";
         m_hist.delete();
      end else begin
         if (abort_i) m_mode = "idle";
         else if (m_mode == "idle") begin
            if (start_i) m_mode = "check";
         end else if (m_mode == "check") begin
            if (seen) begin m_mode = "strobe"; m_left = STROBE_N; end
            else m_mode = "stall";
         end else if (m_mode == "strobe") begin
            if (m_left == 1) m_mode = "latch"; else m_left--;
         end else if (m_mode == "latch") begin
            m_mode = "tail"; m_left = TAIL_N;
         end else if (m_mode == "tail") begin
            if (m_left == 1) m_mode = "idle"; else m_left--;
         end
         m_hist.push_back(pstat_i);
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      bit e_low;
      e_low = (m_mode == "strobe") || (m_mode == "latch") || (m_mode == "tail");
      check("R3", "rd_n_o", rd_n_o, !e_low);
      check("R4", "fifo_push_o", fifo_push_o, (m_mode == "latch") && !fifo_full_i);
      if (fifo_push_o) check("R4", "fifo_data_o", fifo_data_o, bus_i);
      check("R6", "empty_flag_o", empty_flag_o, m_mode == "stall");
      check("R9", "busy_o", busy_o, m_mode != "idle");
      if (fifo_push_o) begin push_cnt++; last_push = fifo_data_o; end
      if (busy_o) busy_cnt++;
   end

   task automatic step(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic pulse_start();
      start_i = 1'b1; step(1); start_i = 1'b0;
   endtask

   task automatic pulse_abort();
      abort_i = 1'b1; step(1); abort_i = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      step(3);
      check("R1", "rd_n_o in reset", rd_n_o, 1);
      check("R1", "busy_o in reset", busy_o, 0);
      rst_n = 1'b1;
      step(1);
      check("R1", "empty_flag_o after reset", empty_flag_o, 0);
      check("R1", "fifo_push_o after reset", fifo_push_o, 0);

      // R3 R4 R10: normal fetch
      pstat_i = 1'b1; bus_i = 8'hA5; step(4);
      push_cnt = 0; busy_cnt = 0;
      pulse_start();
      check("R2", "busy_o after start", busy_o, 1);
      step(10);
      check("R4", "push count", push_cnt, 1);
      check("R4", "pushed byte", last_push, 8'hA5);
      check("R10", "busy length", busy_cnt, 2 + STROBE_N + TAIL_N);

      // R5: full FIFO blocks the push
      fifo_full_i = 1'b1; push_cnt = 0; busy_cnt = 0;
      pulse_start(); step(10);
      check("R5", "push count when full", push_cnt, 0);
      check("R5", "busy length when full", busy_cnt, 2 + STROBE_N + TAIL_N);
      fifo_full_i = 1'b0;

      // R8: start during strobe run
      busy_cnt = 0; push_cnt = 0; bus_i = 8'h3C;
      pulse_start(); step(1); pulse_start(); step(1); pulse_start(); step(8);
      check("R8", "busy length with extra starts", busy_cnt, 2 + STROBE_N + TAIL_N);
      check("R8", "push count with extra starts", push_cnt, 1);

      // R6: empty peripheral stalls
      pstat_i = 1'b0; step(4);
      pulse_start(); step(12);
      check("R6", "stall empty flag", empty_flag_o, 1);
      check("R6", "stall strobe released", rd_n_o, 1);
      pstat_i = 1'b1; pulse_start(); step(5);
      check("R8", "start ignored in stall", empty_flag_o, 1);
      pulse_abort();
      check("R7", "busy after abort", busy_o, 0);
      check("R7", "flag after abort", empty_flag_o, 0);

      // R2: status changed only one edge before start is not yet seen
      pstat_i = 1'b0; step(4);
      pstat_i = 1'b1; pulse_start();
      step(1);
      check("R2", "late status gives stall", empty_flag_o, 1);
      pulse_abort();

      // R7: abort mid-strobe, and abort beating start
      step(3); push_cnt = 0;
      pulse_start(); step(2);
      check("R3", "strobe low mid-run", rd_n_o, 0);
      pulse_abort();
      check("R7", "strobe released by abort", rd_n_o, 1);
      step(6);
      check("R7", "no push after abort", push_cnt, 0);
      start_i = 1'b1; abort_i = 1'b1; step(1); start_i = 1'b0; abort_i = 1'b0;
      check("R7", "abort wins over start", busy_o, 0);
      step(3);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule